// File: doc/BRIEF.md
# Floating-Point Repeat Sequencer

This block sits on the offload path between a single-issue integer core and its floating-point unit. The core hands it floating-point instructions and, now and then, a repeat command. A repeat command carries a body length as an immediate and an iteration count taken from an integer register. The block forwards the next body-length instructions to the FPU as they arrive and records them in a small loop buffer. It then replays them from the buffer for the remaining iterations, one per cycle. The core never issues a counter update or a back-branch per iteration.

The core keeps running while a loop replays. Its integer work never reaches this block. Floating-point instructions it sends after the loop body wait in a short bypass queue and reach the FPU only after the last iteration. This keeps the program order on the FPU side. A repeat command whose length is zero or exceeds the buffer is consumed without effect and flags an error for one cycle.

Top module: `fp_repeat_seq`

## Requirements
- R1: A repeat command with a body length from 1 to BUF_DEPTH (16 by default) is accepted while the block is idle and its bypass queue is empty. `busy` is high from the cycle after acceptance.
- R2: A repeat command with a body length of 0 or above BUF_DEPTH is accepted. It makes `err` high for exactly one cycle, leaves `busy` low and produces no FPU issue.
- R3: With a count value N, the body is issued N+1 times in program order. The first pass goes out as each body instruction arrives, and the later passes come from the loop buffer.
- R4: The count is latched when the command is accepted. Changes on `in_count` afterwards do not alter the number of passes.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_insn` stays unchanged on the next cycle.
- R6: With `out_ready` held high and the body supplied back to back, `busy` stays high for exactly length*(N+1) cycles.
- R7: Plain instructions that arrive after the body during replay are held in a queue of Q_DEPTH (4) entries. `in_ready` for them is low exactly when the queue is full. They reach the FPU, in order, only after the last replayed instruction.
- R8: `busy` falls in the cycle after the FPU accepts the final instruction of the final iteration.
- R9: A repeat command is not accepted (`in_ready` low) while `busy` is high.
- R10: After reset, `out_valid`, `busy` and `err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Core offers an item |
| in_ready | output | 1 | Block takes the offered item this cycle |
| in_is_rep | input | 1 | 1: item is a repeat command, 0: item is an FP instruction |
| in_insn | input | INSN_W | FP instruction word |
| in_count | input | CNT_W | Integer register value giving extra iterations |
| in_len | input | LEN_W | Body length immediate |
| out_valid | output | 1 | Instruction offered to the FPU |
| out_ready | input | 1 | FPU accepts the offered instruction |
| out_insn | output | INSN_W | Instruction word to the FPU |
| busy | output | 1 | Repeat loop in progress |
| err | output | 1 | One-cycle pulse for a rejected repeat command |

## Verification
The bench builds the block with its defaults: a 16-entry loop buffer, a 4-entry bypass queue, 8-bit length and count fields and 32-bit instruction words. The 8-bit length field makes both kinds of bad length reachable: zero, and 17 to 255. Every body length from 1 to the full buffer is legal, so the randomised loops reach the last buffer slot and the point where the read index wraps. The 4-entry queue is small enough that a loop of 31 passes fills it. This exposes the stall on the input side and the draining order afterwards.

// File: rtl/fprs_pkg.sv
package fprs_pkg;

   // Sequencer phases: pass-through, body capture with first issue, replay from buffer
   typedef enum logic [1:0] {
      SEQ_IDLE    = 2'd0,
      SEQ_CAPTURE = 2'd1,
      SEQ_REPLAY  = 2'd2
   } seq_state_e;

   function automatic int idx_width(input int depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/fprs_loop_buf.sv
module fprs_loop_buf #(
   parameter int DEPTH  = 16,
   parameter int WIDTH  = 32,
   parameter int IDX_W  = fprs_pkg::idx_width(DEPTH)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [WIDTH-1:0] rd_data
);

   logic [WIDTH-1:0] slot [DEPTH];

   // one register per slot, each with its own decoded enable
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (wr_en && (int'(wr_idx) == g)) begin
            slot[g] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (int'(rd_idx) == i) rd_data = slot[i];
      end
   end

endmodule

// File: rtl/fprs_fifo.sv
module fprs_fifo #(
   parameter int DEPTH = 4,
   parameter int WIDTH = 32,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full,
   output logic [CNT_W-1:0] count
);

   localparam int PW = fprs_pkg::idx_width(DEPTH);
   localparam bit POW2 = (DEPTH > 1) && ((DEPTH & (DEPTH - 1)) == 0);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   // pointer wrap: free-running for power-of-two depths, explicit compare otherwise
   if (POW2) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (int'(wr_ptr) == DEPTH - 1) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (int'(rd_ptr) == DEPTH - 1) ? '0 : rd_ptr + 1'b1;
   end

   assign empty = (count == '0);
   assign full  = (int'(count) == DEPTH);
   assign head  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push && !full) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push && !full) wr_ptr <= wr_nxt;
         if (pop && !empty) rd_ptr <= rd_nxt;
         case ({push && !full, pop && !empty})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/fprs_ctrl.sv
module fprs_ctrl
   import fprs_pkg::*;
#(
   parameter int BUF_DEPTH = 16,
   parameter int CNT_W     = 8,
   parameter int LEN_W     = 8,
   parameter int IDX_W     = fprs_pkg::idx_width(BUF_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_is_rep,
   input  logic [CNT_W-1:0] in_count,
   input  logic [LEN_W-1:0] in_len,
   input  logic             out_ready,
   input  logic             q_empty,
   input  logic             q_full,
   output logic             in_ready,
   output seq_state_e       state,
   output logic             buf_we,
   output logic [IDX_W-1:0] wr_idx,
   output logic [IDX_W-1:0] rd_idx,
   output logic             q_push,
   output logic             q_pop,
   output logic             err
);

   logic [IDX_W-1:0] last_idx;
   logic [CNT_W-1:0] iter_left;
   logic             len_ok;
   logic             take;
   logic             rep_take;
   logic             body_take;
   logic             replay_fire;

   assign len_ok = (in_len != '0) && (int'(in_len) <= BUF_DEPTH);

   always_comb begin
      case (state)
         SEQ_IDLE:    in_ready = in_is_rep ? q_empty : !q_full;
         SEQ_CAPTURE: in_ready = in_is_rep ? 1'b0 : out_ready;
         SEQ_REPLAY:  in_ready = in_is_rep ? 1'b0 : !q_full;
         default:     in_ready = 1'b0;
      endcase
   end

   assign take        = in_valid && in_ready;
   assign rep_take    = take && in_is_rep;
   assign body_take   = take && !in_is_rep && (state == SEQ_CAPTURE);
   assign replay_fire = (state == SEQ_REPLAY) && out_ready;

   assign buf_we = body_take;
   assign q_push = take && !in_is_rep && (state != SEQ_CAPTURE);
   assign q_pop  = (state == SEQ_IDLE) && out_ready && !q_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SEQ_IDLE;
         last_idx  <= '0;
         iter_left <= '0;
         wr_idx    <= '0;
         rd_idx    <= '0;
         err       <= 1'b0;
      end else begin
         err <= 1'b0;
         case (state)
            SEQ_IDLE: begin
               if (rep_take) begin
                  if (len_ok) begin
                     state     <= SEQ_CAPTURE;
                     last_idx  <= IDX_W'(in_len - 1'b1);
                     iter_left <= in_count;
                     wr_idx    <= '0;
                  end else begin
                     err <= 1'b1;
                  end
               end
            end
            SEQ_CAPTURE: begin
               if (body_take) begin
                  if (wr_idx == last_idx) begin
                     rd_idx <= '0;
                     state  <= (iter_left == '0) ? SEQ_IDLE : SEQ_REPLAY;
                  end else begin
                     wr_idx <= wr_idx + 1'b1;
                  end
               end
            end
            SEQ_REPLAY: begin
               if (replay_fire) begin
                  if (rd_idx == last_idx) begin
                     rd_idx <= '0;
                     if (iter_left == CNT_W'(1)) state <= SEQ_IDLE;
                     else                        iter_left <= iter_left - 1'b1;
                  end else begin
                     rd_idx <= rd_idx + 1'b1;
                  end
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/fp_repeat_seq.sv
module fp_repeat_seq
   import fprs_pkg::*;
#(
   parameter int INSN_W    = 32,
   parameter int BUF_DEPTH = 16,
   parameter int Q_DEPTH   = 4,
   parameter int CNT_W     = 8,
   parameter int LEN_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_is_rep,
   input  logic [INSN_W-1:0] in_insn,
   input  logic [CNT_W-1:0]  in_count,
   input  logic [LEN_W-1:0]  in_len,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [INSN_W-1:0] out_insn,
   output logic              busy,
   output logic              err
);

   localparam int IDX_W = fprs_pkg::idx_width(BUF_DEPTH);
   localparam int QCW   = $clog2(Q_DEPTH + 1);

   // elaboration-time parameter checks
   if (BUF_DEPTH < 1) begin : g_bad_depth
      $error("BUF_DEPTH must be at least 1");
   end
   if ((2 ** LEN_W) <= BUF_DEPTH) begin : g_bad_len_w
      $error("LEN_W too narrow to express BUF_DEPTH");
   end
   if (Q_DEPTH < 1) begin : g_bad_q
      $error("Q_DEPTH must be at least 1");
   end
   if (CNT_W < 1 || INSN_W < 1) begin : g_bad_w
      $error("CNT_W and INSN_W must be positive");
   end

   seq_state_e        state;
   logic              buf_we;
   logic [IDX_W-1:0]  wr_idx, rd_idx;
   logic [INSN_W-1:0] buf_rd;
   logic              q_push, q_pop, q_empty, q_full;
   logic [INSN_W-1:0] q_head;
   logic [QCW-1:0]    q_cnt;

   fprs_ctrl #(
      .BUF_DEPTH (BUF_DEPTH),
      .CNT_W     (CNT_W),
      .LEN_W     (LEN_W),
      .IDX_W     (IDX_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_is_rep (in_is_rep),
      .in_count  (in_count),
      .in_len    (in_len),
      .out_ready (out_ready),
      .q_empty   (q_empty),
      .q_full    (q_full),
      .in_ready  (in_ready),
      .state     (state),
      .buf_we    (buf_we),
      .wr_idx    (wr_idx),
      .rd_idx    (rd_idx),
      .q_push    (q_push),
      .q_pop     (q_pop),
      .err       (err)
   );

   fprs_loop_buf #(
      .DEPTH (BUF_DEPTH),
      .WIDTH (INSN_W),
      .IDX_W (IDX_W)
   ) u_loop_buf (
      .clk     (clk),
      .wr_en   (buf_we),
      .wr_idx  (wr_idx),
      .wr_data (in_insn),
      .rd_idx  (rd_idx),
      .rd_data (buf_rd)
   );

   fprs_fifo #(
      .DEPTH (Q_DEPTH),
      .WIDTH (INSN_W),
      .CNT_W (QCW)
   ) u_bypass_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push),
      .push_data (in_insn),
      .pop       (q_pop),
      .head      (q_head),
      .empty     (q_empty),
      .full      (q_full),
      .count     (q_cnt)
   );

   // issue source selection per phase
   always_comb begin
      case (state)
         SEQ_CAPTURE: begin
            out_valid = in_valid && !in_is_rep;
            out_insn  = in_insn;
         end
         SEQ_REPLAY: begin
            out_valid = 1'b1;
            out_insn  = buf_rd;
         end
         default: begin
            out_valid = !q_empty;
            out_insn  = q_head;
         end
      endcase
   end

   assign busy = (state != SEQ_IDLE);

endmodule

// File: rtl/fprs_checker.sv
module fprs_checker #(
   parameter int INSN_W  = 32,
   parameter int Q_DEPTH = 4,
   parameter int QCW     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              in_is_rep,
   input logic              out_valid,
   input logic              out_ready,
   input logic [INSN_W-1:0] out_insn,
   input logic              busy,
   input logic              err,
   input logic [QCW-1:0]    q_cnt
);

   assert_busy_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(in_valid && in_ready && in_is_rep));

   assert_err_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!busy && $past(in_valid && in_ready && in_is_rep)));

   assert_err_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_insn)));

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(q_cnt) <= Q_DEPTH);

   assert_rep_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && in_is_rep) |-> !in_ready);

endmodule

bind fp_repeat_seq fprs_checker #(
   .INSN_W  (INSN_W),
   .Q_DEPTH (Q_DEPTH),
   .QCW     (QCW)
) u_fprs_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_is_rep (in_is_rep),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_insn  (out_insn),
   .busy      (busy),
   .err       (err),
   .q_cnt     (q_cnt)
);

// File: tb/tb_fp_repeat_seq.sv
module tb_fp_repeat_seq;

   localparam int CLK_PERIOD = 10;
   localparam int INSN_W     = 32;
   localparam int BUF_DEPTH  = 16;
   localparam int Q_DEPTH    = 4;
   localparam int CNT_W      = 8;
   localparam int LEN_W      = 8;
   localparam int WATCHDOG   = 150000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic              in_is_rep = 1'b0;
   logic [INSN_W-1:0] in_insn = '0;
   logic [CNT_W-1:0]  in_count = '0;
   logic [LEN_W-1:0]  in_len = '0;
   logic              out_valid;
   logic              out_ready = 1'b0;
   logic [INSN_W-1:0] out_insn;
   logic              busy;
   logic              err;

   fp_repeat_seq #(
      .INSN_W    (INSN_W),
      .BUF_DEPTH (BUF_DEPTH),
      .Q_DEPTH   (Q_DEPTH),
      .CNT_W     (CNT_W),
      .LEN_W     (LEN_W)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_is_rep (in_is_rep),
      .in_insn   (in_insn),
      .in_count  (in_count),
      .in_len    (in_len),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_insn  (out_insn),
      .busy      (busy),
      .err       (err)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int          checks = 0;
   int          errors = 0;
   int          cycles = 0;
   bit          finished = 1'b0;
   bit          mon_on = 1'b0;
   bit          ready_hi = 1'b0;
   bit          busy_meas = 1'b0;
   int          busy_cnt = 0;
   int          q_model = 0;
   bit          pend_busy = 1'b0;
   int unsigned seq_no = 0;
   logic [INSN_W-1:0] exp_q[$];

   function automatic void chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endfunction

   function automatic logic [INSN_W-1:0] next_insn();
      seq_no++;
      return INSN_W'(32'hF000_0000 | seq_no);
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) cycles++;

   initial begin
      wait (cycles >= WATCHDOG);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      finish_run();
   end

   // FPU side: ready pattern, stability and stream comparison
   initial begin
      bit                prev_stall = 1'b0;
      logic [INSN_W-1:0] prev_insn = '0;
      forever begin
         @(negedge clk);
         out_ready = ready_hi ? 1'b1 : (($urandom % 4) != 0);
         #1;
         if (mon_on) begin
            if (busy_meas && busy) busy_cnt++;
            if (prev_stall) begin
               chk(out_valid && (out_insn == prev_insn), "R5", "held insn", out_insn, prev_insn);
            end
            if (out_valid && out_ready) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R3", "unexpected issue", out_insn, 0);
               end else begin
                  logic [INSN_W-1:0] e;
                  e = exp_q.pop_front();
                  chk(out_insn == e, "R3 R4 R7", "issue order", out_insn, e);
               end
            end
            prev_stall = out_valid && !out_ready;
            prev_insn  = out_insn;
         end
      end
   end

   // one item on the core side; body marks a loop body instruction
   task automatic send(bit is_rep, logic [INSN_W-1:0] insn, logic [CNT_W-1:0] cnt,
                       logic [LEN_W-1:0] len, bit body);
      bit acc = 1'b0;
      bit bsy;
      @(negedge clk);
      in_valid  = 1'b1;
      in_is_rep = is_rep;
      in_insn   = insn;
      in_count  = cnt;
      in_len    = len;
      while (!acc) begin
         #1;
         if (pend_busy) begin
            chk(busy == 1'b1, "R1", "busy after command", busy, 1);
            pend_busy = 1'b0;
         end
         bsy = busy;
         if (is_rep && bsy) chk(in_ready == 1'b0, "R9", "command stalled", in_ready, 0);
         if (!is_rep && !body && bsy) begin
            chk(in_ready == (q_model < Q_DEPTH), "R7", "queue ready", in_ready, q_model < Q_DEPTH);
         end
         acc = in_ready;
         @(posedge clk);
         #1;
         if (!acc) @(negedge clk);
      end
      if (!is_rep && !body && bsy) q_model++;
      if (is_rep) q_model = 0;
      in_valid = 1'b0;
      in_count = CNT_W'($urandom);   // register changes after capture: R4
   endtask

   task automatic run_loop(int len, int cnt);
      logic [INSN_W-1:0] body[BUF_DEPTH];
      for (int i = 0; i < len; i++) body[i] = next_insn();
      for (int p = 0; p <= cnt; p++)
         for (int i = 0; i < len; i++) exp_q.push_back(body[i]);
      send(1'b1, '0, CNT_W'(cnt), LEN_W'(len), 1'b0);
      pend_busy = 1'b1;
      for (int i = 0; i < len; i++) send(1'b0, body[i], CNT_W'($urandom), '0, 1'b1);
   endtask

   task automatic send_plain();
      logic [INSN_W-1:0] x;
      x = next_insn();
      exp_q.push_back(x);
      send(1'b0, x, '0, '0, 1'b0);
   endtask

   task automatic send_bad(int len);
      send(1'b1, '0, CNT_W'(3), LEN_W'(len), 1'b0);
      @(negedge clk);
      #1;
      chk(err == 1'b1, "R2", "err pulse", err, 1);
      chk(busy == 1'b0, "R2", "busy after bad length", busy, 0);
      @(negedge clk);
      #1;
      chk(err == 1'b0, "R2", "err one cycle", err, 0);
   endtask

   task automatic drain();
      while (exp_q.size() != 0 || busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      #1;
      chk(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
      chk(busy == 1'b0, "R10", "busy after reset", busy, 0);
      chk(err == 1'b0, "R10", "err after reset", err, 0);
      chk(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
      mon_on = 1'b1;

      // R6 R8: back-to-back body, FPU always ready, busy length
      ready_hi = 1'b1;
      busy_meas = 1'b1;
      busy_cnt = 0;
      run_loop(3, 4);
      drain();
      busy_meas = 1'b0;
      chk(busy_cnt == 15, "R6 R8", "busy cycles", busy_cnt, 15);

      // single instruction, single pass, then full buffer
      busy_meas = 1'b1;
      busy_cnt = 0;
      run_loop(1, 0);
      drain();
      busy_meas = 1'b0;
      chk(busy_cnt == 1, "R8", "busy cycles one pass", busy_cnt, 1);
      run_loop(BUF_DEPTH, 2);
      drain();

      // R7: fill the bypass queue during a long replay
      run_loop(1, 30);
      for (int k = 0; k < Q_DEPTH + 2; k++) send_plain();
      drain();

      // R9: command offered while the previous loop runs
      ready_hi = 1'b0;
      run_loop(2, 6);
      run_loop(3, 1);
      drain();

      // R2: bad lengths, boundaries and beyond
      send_bad(0);
      send_bad(BUF_DEPTH + 1);
      send_bad(255);
      drain();

      // constrained random mix
      for (int n = 0; n < 60; n++) begin
         int pick;
         pick = int'($urandom % 10);
         ready_hi = (($urandom % 3) == 0);
         if (pick < 5)      send_plain();
         else if (pick < 9) run_loop(1 + int'($urandom % BUF_DEPTH), int'($urandom % 6));
         else               send_bad((($urandom % 2) == 0) ? 0 : BUF_DEPTH + 1 + int'($urandom % 100));
      end
      drain();
      chk(exp_q.size() == 0, "R3", "stream complete", exp_q.size(), 0);
      finish_run();
   end

endmodule